// File: doc/BRIEF.md
# Packet Acknowledge and Retry Controller

This block sits on the sending side of a link. It holds one packet at a time and enforces the rule that each packet gets exactly one acknowledgment. A packet enters from a descriptor queue as a stream of flits. The first flit carries the route information, and the remaining flits are transactions. The block stores the packet locally and sends it over a flit transmit port. It flags the last transaction so that the receiver knows to acknowledge. It then keeps the path open and sends nothing further until an acknowledgment token returns. Only after that token arrives does it send the end-of-packet token that releases the path.

Two events abort an attempt and replay the packet from the local buffer:
- an error token arriving while the packet is being sent or while the acknowledgment is awaited;
- a wait for the acknowledgment that lasts too long.

A programmable limit bounds the number of replays. When that limit is used up, the block reports a fault together with the route identifier of the failed packet, and it returns to idle without sending an end-of-packet token.

Top module: `pkt_ack_retry_ctrl`

## Requirements
- R1: After reset the block is idle: `in_ready`=1, `tx_valid`=0, `busy`=0, `done`=0, `fault`=0.
- R2: A packet is sent in load order, one flit per transmit handshake. The first flit goes out with `tx_kind`=0 (route). Every later flit goes out with `tx_kind`=1 (transaction). Transmission starts in the cycle after the flit carrying `in_last` is accepted.
- R3: `tx_ack_now` is 1 on the final flit of the packet and 0 on every other flit.
- R4: After the final flit, `tx_valid` stays 0 until `rx_ack` is seen. In the cycle after `rx_ack`, the end-of-packet token is offered with `tx_kind`=2. In the cycle after that token is taken, `done` pulses for one cycle and the block is idle.
- R5: `rx_ack` has no effect while the block is idle or while the packet is being sent. Such an early token does not release the path.
- R6: An `rx_err` token, received either while sending or while waiting, restarts the packet from its route flit in the next cycle, provided a replay remains.
- R7: If `TIMEOUT` consecutive waiting cycles pass without a token, the block acts as if an error had arrived. An `rx_ack` presented in the last of those cycles still counts as an acknowledgment.
- R8: If `rx_ack` and `rx_err` arrive in the same cycle, the error takes precedence.
- R9: The replay limit is a 4-bit register with reset value 3, loaded from `cfg_retry_limit` when `cfg_we`=1. Each packet may be replayed that many times. The next failure after the last allowed replay produces a one-cycle `fault` pulse. That pulse carries the packet's route identifier on `fault_route`, and the block returns to idle with no end-of-packet token sent.
- R10: `in_ready` is 1 only while idle. A packet holds at most `MAX_FLITS` (16) flits, and a 16-flit packet is sent in full with the acknowledge-now flag on its 16th flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet flit offered by the descriptor queue |
| in_ready | output | 1 | Block accepts a packet flit |
| in_data | input | FLIT_W | Packet flit (route word first) |
| in_last | input | 1 | Marks the final flit of the packet being loaded |
| in_route_id | input | ROUTE_W | Route identifier, sampled with the first flit |
| tx_valid | output | 1 | Outgoing flit or token valid |
| tx_ready | input | 1 | Link takes the outgoing flit |
| tx_kind | output | 2 | 0 route, 1 transaction, 2 end-of-packet |
| tx_data | output | FLIT_W | Outgoing flit payload (0 for end-of-packet) |
| tx_ack_now | output | 1 | Acknowledge-now flag on the final flit |
| rx_ack | input | 1 | Packet acknowledgment token received |
| rx_err | input | 1 | Error token received |
| cfg_we | input | 1 | Load the replay limit |
| cfg_retry_limit | input | 4 | New replay limit |
| busy | output | 1 | A packet is in flight |
| done | output | 1 | One-cycle pulse: packet completed |
| fault | output | 1 | One-cycle pulse: replays exhausted |
| fault_route | output | ROUTE_W | Route identifier of the last failed packet |

## Verification
The acknowledgment deadline and the acknowledgment itself can meet in one cycle, and so can an acknowledgment and an error token. For the first case, the bench waits exactly `TIMEOUT`-1 idle waiting cycles and then presents `rx_ack` in the final counted cycle. The result is judged correct when the next cycle shows an end-of-packet token rather than a replayed route flit. For the second case, the bench raises `rx_ack` and `rx_err` together and requires the route flit to reappear, which is the error-first ordering.

// File: rtl/par_pkg.sv
// Shared types for the packet acknowledge and retry controller.
// Assumes: two-bit flit kind code that the link side decodes.
package par_pkg;
    typedef enum logic [1:0] {
        KIND_ROUTE = 2'd0,
        KIND_TRANS = 2'd1,
        KIND_EOP   = 2'd2
    } flit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_EOP  = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/par_flit_store.sv
// Replay buffer: holds one packet of up to DEPTH flits.
// Written sequentially from index 0; read at any index; cleared as a whole.
// Assumes the writer never writes while count equals DEPTH.
module par_flit_store #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [FLIT_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [FLIT_W-1:0] mem [DEPTH];

    // Store each written flit at the next free slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[count[IDX_W-1:0]] <= wr_data;
        end
    end

    // Track the number of stored flits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr_en) begin
            count <= count + 1'b1;
        end
    end

    // Random-access read for transmission.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/par_ack_timer.sv
// Acknowledgment deadline: counts cycles while run is high.
// Raises expired in the TIMEOUT-th consecutive run cycle; restarts when run drops.
// Assumes TIMEOUT >= 2.
module par_ack_timer #(
    parameter int TIMEOUT = 64,
    localparam int TW = $clog2(TIMEOUT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    // Final counted cycle of the waiting window.
    assign expired = run && (cnt == TW'(TIMEOUT - 1));

    // Count waiting cycles and restart outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/par_retry_budget.sv
// Replay budget of one packet: counts replays and compares against the limit.
// Assumes bump is only raised while exhausted is low.
module par_retry_budget #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    input  logic [LIM_W-1:0] limit,
    output logic             exhausted
);
    logic [LIM_W-1:0] used;

    // No replay left once used reaches the limit.
    assign exhausted = (used >= limit);

    // Count the replays granted to the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (clr) begin
            used <= '0;
        end else if (bump) begin
            used <= used + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_ack_retry_ctrl.sv
// Source-side packet controller: loads one packet, sends route flit and transactions,
// flags the last one, waits for one acknowledgment, then sends end-of-packet.
// Error tokens and acknowledgment timeouts replay the packet up to a limit, then fault.
// Assumes packets of 1..MAX_FLITS flits with route id valid on the first flit.
module pkt_ack_retry_ctrl
    import par_pkg::*;
#(
    parameter int FLIT_W    = 16,
    parameter int ROUTE_W   = 8,
    parameter int MAX_FLITS = 16,
    parameter int TIMEOUT   = 64,
    parameter int LIM_W     = 4,
    parameter logic [LIM_W-1:0] LIMIT_RST = 4'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FLIT_W-1:0]  in_data,
    input  logic               in_last,
    input  logic [ROUTE_W-1:0] in_route_id,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [1:0]         tx_kind,
    output logic [FLIT_W-1:0]  tx_data,
    output logic               tx_ack_now,
    input  logic               rx_ack,
    input  logic               rx_err,
    input  logic               cfg_we,
    input  logic [LIM_W-1:0]   cfg_retry_limit,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [ROUTE_W-1:0] fault_route
);
    localparam int IDX_W = $clog2(MAX_FLITS);
    localparam int CNT_W = $clog2(MAX_FLITS + 1);

    ctrl_state_e          state;
    logic [IDX_W-1:0]     rd_idx;
    logic [CNT_W-1:0]     count;
    logic [FLIT_W-1:0]    rd_data;
    logic [ROUTE_W-1:0]   route_q;
    logic [LIM_W-1:0]     limit_q;
    logic                 expired;
    logic                 exhausted;
    logic                 accept;
    logic                 tx_fire;
    logic                 at_last;
    logic                 fail_evt;
    logic                 retry_ok;
    logic                 give_up;
    logic                 finish;
    flit_kind_e           kind_w;

    // Handshake and event decode.
    assign in_ready = (state == ST_IDLE) && (count != CNT_W'(MAX_FLITS));
    assign accept   = in_valid && in_ready;
    assign tx_fire  = tx_valid && tx_ready;
    assign at_last  = (CNT_W'(rd_idx) == count - 1'b1);
    assign fail_evt = ((state == ST_SEND) && rx_err) ||
                      ((state == ST_WAIT) && (rx_err || (expired && !rx_ack)));
    assign retry_ok = fail_evt && !exhausted;
    assign give_up  = fail_evt && exhausted;
    assign finish   = (state == ST_EOP) && tx_fire;
    assign busy     = (state != ST_IDLE);

    // Transmit port view of the current state.
    always_comb begin
        tx_valid   = 1'b0;
        kind_w     = KIND_TRANS;
        tx_data    = '0;
        tx_ack_now = 1'b0;
        if (state == ST_SEND) begin
            tx_valid   = 1'b1;
            kind_w     = (rd_idx == '0) ? KIND_ROUTE : KIND_TRANS;
            tx_data    = rd_data;
            tx_ack_now = at_last;
        end else if (state == ST_EOP) begin
            tx_valid = 1'b1;
            kind_w   = KIND_EOP;
        end
    end
    assign tx_kind = kind_w;

    par_flit_store #(.FLIT_W(FLIT_W), .DEPTH(MAX_FLITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (finish || give_up),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .count   (count)
    );

    par_ack_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    par_retry_budget #(.LIM_W(LIM_W)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept && in_last),
        .bump      (retry_ok),
        .limit     (limit_q),
        .exhausted (exhausted)
    );

    // Programmable replay limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RST;
        end else if (cfg_we) begin
            limit_q <= cfg_retry_limit;
        end
    end

    // Main sequencing: load, send, wait for acknowledgment, release path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_idx  <= '0;
            route_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (count == '0) begin
                            route_q <= in_route_id;
                        end
                        if (in_last) begin
                            state  <= ST_SEND;
                            rd_idx <= '0;
                        end
                    end
                end
                ST_SEND: begin
                    if (rx_err) begin
                        state  <= retry_ok ? ST_SEND : ST_IDLE;
                        rd_idx <= '0;
                    end else if (tx_fire) begin
                        if (at_last) begin
                            state <= ST_WAIT;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fail_evt) begin
                        state  <= retry_ok ? ST_SEND : ST_IDLE;
                        rd_idx <= '0;
                    end else if (rx_ack) begin
                        state <= ST_EOP;
                    end
                end
                ST_EOP: begin
                    if (tx_fire) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle outcome pulses and failing route capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            fault       <= 1'b0;
            fault_route <= '0;
        end else begin
            done  <= finish;
            fault <= give_up;
            if (give_up) begin
                fault_route <= route_q;
            end
        end
    end
endmodule

// File: rtl/pkt_ack_retry_chk.sv
// Protocol checker for pkt_ack_retry_ctrl, attached by bind; observes ports only.
// Assumes tx_kind codes 0 route, 1 transaction, 2 end-of-packet.
module pkt_ack_retry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [1:0] tx_kind,
    input logic       tx_ack_now,
    input logic       rx_ack,
    input logic       rx_err,
    input logic       busy,
    input logic       done,
    input logic       fault
);
    logic ack_seen;

    // Remember an acknowledgment taken while the path was held open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_seen <= 1'b0;
        end else if (tx_valid && tx_ready && tx_kind == 2'd0) begin
            ack_seen <= 1'b0;
        end else if (busy && !tx_valid && rx_ack && !rx_err) begin
            ack_seen <= 1'b1;
        end
    end

    AST_EOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd2) |-> ack_seen); // R4
    AST_ROUTE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (tx_valid && tx_kind == 2'd0)); // R2
    AST_HOLD_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_ack_now && !rx_err) |=> !tx_valid); // R3
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy); // R10
    AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && !tx_valid)); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault})); // R9
endmodule

bind pkt_ack_retry_ctrl pkt_ack_retry_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_kind    (tx_kind),
    .tx_ack_now (tx_ack_now),
    .rx_ack     (rx_ack),
    .rx_err     (rx_err),
    .busy       (busy),
    .done       (done),
    .fault      (fault)
);

// File: tb/pkt_ack_retry_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for pkt_ack_retry_ctrl: one task per scenario, each checking itself.
module pkt_ack_retry_ctrl_bench;
    localparam int FLIT_W  = 16;
    localparam int ROUTE_W = 8;
    localparam int TMO     = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [FLIT_W-1:0]  in_data = '0;
    logic               in_last = 1'b0;
    logic [ROUTE_W-1:0] in_route_id = '0;
    logic               tx_valid;
    logic               tx_ready = 1'b1;
    logic [1:0]         tx_kind;
    logic [FLIT_W-1:0]  tx_data;
    logic               tx_ack_now;
    logic               rx_ack = 1'b0;
    logic               rx_err = 1'b0;
    logic               cfg_we = 1'b0;
    logic [3:0]         cfg_retry_limit = '0;
    logic               busy;
    logic               done;
    logic               fault;
    logic [ROUTE_W-1:0] fault_route;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pkt_ack_retry_ctrl #(.TIMEOUT(TMO)) u_pkt_ack_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_route_id(in_route_id),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
        .tx_data(tx_data), .tx_ack_now(tx_ack_now), .rx_ack(rx_ack),
        .rx_err(rx_err), .cfg_we(cfg_we), .cfg_retry_limit(cfg_retry_limit),
        .busy(busy), .done(done), .fault(fault), .fault_route(fault_route)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Load n flits (base+i) with route id rid; ends at the negedge showing flit 0.
    task automatic load_pkt(input int n, input int rid, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R10", "in_ready while idle", int'(in_ready), 1);
            in_valid    = 1'b1;
            in_data     = FLIT_W'(base + i);
            in_last     = (i == n - 1);
            in_route_id = ROUTE_W'(rid);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Check `shown` flits of a packet of `total`, one per cycle.
    task automatic expect_flits(input int shown, input int total, input int base);
        for (int i = 0; i < shown; i++) begin
            chk("R2", "tx_valid", int'(tx_valid), 1);
            chk("R2", "tx_kind", int'(tx_kind), (i == 0) ? 0 : 1);
            chk("R2", "tx_data", int'(tx_data), base + i);
            chk("R3", "tx_ack_now", int'(tx_ack_now), (i == total - 1) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input bit a, input bit e);
        rx_ack = a;
        rx_err = e;
        @(negedge clk);
        rx_ack = 1'b0;
        rx_err = 1'b0;
    endtask

    // Acknowledge, then expect end-of-packet and the done pulse.
    task automatic ack_and_close(input string req);
        pulse(1'b1, 1'b0);
        chk(req, "eop valid", int'(tx_valid), 1);
        chk(req, "eop kind", int'(tx_kind), 2);
        @(negedge clk);
        chk("R4", "done pulse", int'(done), 1);
        chk("R4", "idle after done", int'(busy), 0);
        @(negedge clk);
        chk("R4", "done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "tx_valid", int'(tx_valid), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "fault", int'(fault), 0);
    endtask

    task automatic t_normal;
        load_pkt(3, 8'h11, 16'h100);
        expect_flits(3, 3, 16'h100);
        for (int k = 0; k < 5; k++) begin
            chk("R4", "held without ack", int'(tx_valid), 0);
            chk("R10", "in_ready low while busy", int'(in_ready), 0);
            @(negedge clk);
        end
        ack_and_close("R4");
    endtask

    task automatic t_spurious_ack;
        pulse(1'b1, 1'b0);
        chk("R5", "idle ack no tx", int'(tx_valid), 0);
        chk("R5", "idle ack no busy", int'(busy), 0);
        chk("R5", "idle ack no done", int'(done), 0);
        load_pkt(2, 8'h12, 16'h200);
        rx_ack = 1'b1;
        expect_flits(2, 2, 16'h200);
        rx_ack = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R5", "early ack ignored", int'(tx_valid), 0);
            @(negedge clk);
        end
        ack_and_close("R5");
    endtask

    task automatic t_err_wait;
        load_pkt(2, 8'h22, 16'h300);
        expect_flits(2, 2, 16'h300);
        pulse(1'b0, 1'b1);
        expect_flits(2, 2, 16'h300); // R6 replay
        ack_and_close("R6");
    endtask

    task automatic t_err_send;
        load_pkt(4, 8'h23, 16'h400);
        expect_flits(1, 4, 16'h400);
        pulse(1'b0, 1'b1);
        chk("R6", "replay from route", int'(tx_kind), 0);
        expect_flits(4, 4, 16'h400);
        ack_and_close("R6");
    endtask

    task automatic t_timeout;
        load_pkt(2, 8'h24, 16'h500);
        expect_flits(2, 2, 16'h500);
        for (int k = 0; k < TMO; k++) begin
            chk("R7", "quiet wait", int'(tx_valid), 0);
            @(negedge clk);
        end
        chk("R7", "timeout replays", int'(tx_kind), 0);
        expect_flits(2, 2, 16'h500);
        ack_and_close("R7");
    endtask

    task automatic t_ack_at_deadline;
        load_pkt(2, 8'h25, 16'h600);
        expect_flits(2, 2, 16'h600);
        repeat (TMO - 1) @(negedge clk);
        chk("R7", "still waiting", int'(tx_valid), 0);
        ack_and_close("R7");
    endtask

    task automatic t_ack_err_same;
        load_pkt(2, 8'h26, 16'h700);
        expect_flits(2, 2, 16'h700);
        pulse(1'b1, 1'b1);
        chk("R8", "error wins kind", int'(tx_kind), 0);
        chk("R8", "error wins valid", int'(tx_valid), 1);
        expect_flits(2, 2, 16'h700);
        ack_and_close("R8");
    endtask

    task automatic t_default_limit;
        load_pkt(2, 8'h5A, 16'h800);
        for (int r = 0; r < 3; r++) begin
            expect_flits(2, 2, 16'h800);
            pulse(1'b0, 1'b1);
        end
        expect_flits(2, 2, 16'h800);
        pulse(1'b0, 1'b1);
        chk("R9", "fault pulse", int'(fault), 1);
        chk("R9", "fault route", int'(fault_route), 8'h5A);
        chk("R9", "no eop on fault", int'(tx_valid), 0);
        chk("R9", "idle on fault", int'(in_ready), 1);
        @(negedge clk);
        chk("R9", "fault one cycle", int'(fault), 0);
        chk("R9", "no done after fault", int'(done), 0);
    endtask

    task automatic t_zero_limit;
        cfg_we = 1'b1;
        cfg_retry_limit = 4'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        load_pkt(2, 8'h33, 16'h900);
        expect_flits(2, 2, 16'h900);
        pulse(1'b0, 1'b1);
        chk("R9", "zero limit fault", int'(fault), 1);
        chk("R9", "zero limit route", int'(fault_route), 8'h33);
        chk("R9", "zero limit idle", int'(busy), 0);
        cfg_we = 1'b1;
        cfg_retry_limit = 4'd3;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_full_packet;
        load_pkt(16, 8'h44, 16'hA00);
        expect_flits(16, 16, 16'hA00); // R10 sixteen flits
        chk("R10", "no load while waiting", int'(in_ready), 0);
        ack_and_close("R10");
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_spurious_ack();
        t_err_wait();
        t_err_send();
        t_timeout();
        t_ack_at_deadline();
        t_ack_err_same();
        t_default_limit();
        t_zero_limit();
        t_full_packet();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule